// File: doc/BRIEF.md
# Remote DMA Data Port

The block gives a host byte-serial access to a packet memory through one data port. The host first programs a 16-bit memory address and a 16-bit transfer count, one byte at a time, over a small register write port. It then moves data by strobing the data port once per transfer. Each strobe moves one, two or four bytes, little-endian, at the current address. The address then steps forward, and the count steps down by the same amount.

The address is held inside a receive ring, set by a first page and a stop page. When the stepped address lands exactly on the stop address it jumps back to the ring's first address. When the count runs out, a completion flag is raised in an interrupt status register. That flag, gated by a mask register, drives a level interrupt line. The memory is held inside the block. It is reachable in two regions: a small low region at address 0 and a packet window at a parameterised base. Every other address reads as all ones and ignores writes.

Top module: `rdma_port`

## Requirements
- R1: The address register is loaded through register select 1 (low byte) and select 2 (high byte). The count register is loaded through select 3 (low byte) and select 4 (high byte). Each byte write leaves the other half unchanged.
- R2: Data port size 2 or 3 moves 4 bytes. Size 0 or 1 moves 1 byte when configuration bit 0 (select 7) is 0, and 2 bytes when it is 1. Bytes are little-endian, with the lowest address in bits 7:0. Read data is registered and valid on the cycle after the strobe. Lanes beyond the access size read as 0.
- R3: A 2- or 4-byte access uses the current address with bit 0 cleared. The address itself steps from its unaligned value.
- R4: After each access the address grows by the access size. If the result equals the stop address {stop page (select 6), 8'h00}, the address becomes {first page (select 5), 8'h00}.
- R5: After an access, if the count is not greater than the access size, the count becomes 0 and status bit 6 is set. Otherwise the count drops by the access size. Reads proceed even at count 0.
- R6: A data port write (dp_wr_i high, dp_rd_i low) while the count is 0 is ignored. It changes neither the memory, the address nor the count.
- R7: A write to select 0 with bit 0 clear always clears status bit 7. If that write also has bit 3 or bit 4 set while the count is 0, it sets status bit 6. A write with bit 0 set changes neither status bit.
- R8: An access is in range only if all of its bytes lie below LOW_BYTES (32), or all lie in [WIN_BASE, WIN_BASE+WIN_BYTES), by default [0x0400, 0x0800). Out-of-range reads return 8'hFF in each active lane, and out-of-range writes are dropped.
- R9: A write to select 9 clears each status bit 0 to 6 that is written as 1.
- R10: After reset the status is 8'h80, the mask and read data are 0, and irq_o is low. irq_o is high exactly when some bit 0 to 6 of (status AND mask, mask at select 8) is set. Bit 7 never drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register byte write strobe |
| reg_sel_i | input | 4 | Register select |
| reg_wdata_i | input | 8 | Register write byte |
| dp_rd_i | input | 1 | Data port read strobe |
| dp_wr_i | input | 1 | Data port write strobe |
| dp_size_i | input | 2 | Data port access size |
| dp_wdata_i | input | 32 | Data port write data |
| dp_rdata_o | output | 32 | Data port read data, registered |
| status_o | output | 8 | Interrupt status register |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench sweeps hundreds of byte transfers and reads them back in several sizes. Any error in lane order or address alignment then shows up as swapped or shifted bytes. It steps byte, word and longword transfers across the stop address; a design that wrapped at the memory end or checked before stepping would land data outside the ring. It drives counts that are not a multiple of the access size and writes at a count of zero. A design that underflowed the count, raised completion early, or let the ignored write move the address would read back the wrong old byte. It also probes accesses that straddle a region edge, which must read all ones rather than wrap into neighbouring storage.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  typedef enum logic [3:0] {
    RG_CMD    = 4'd0,
    RG_ADR_LO = 4'd1,
    RG_ADR_HI = 4'd2,
    RG_CNT_LO = 4'd3,
    RG_CNT_HI = 4'd4,
    RG_RING_F = 4'd5,
    RG_RING_S = 4'd6,
    RG_CFG    = 4'd7,
    RG_MASK   = 4'd8,
    RG_CLR    = 4'd9
  } reg_sel_e;

  localparam int CMD_HALT = 0;
  localparam int CMD_RRD  = 3;
  localparam int CMD_RWR  = 4;
  localparam int ST_DONE  = 6;
  localparam int ST_RST   = 7;
endpackage

// File: rtl/rdma_regs.sv
module rdma_regs
  import rdma_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [3:0]    sel_i,
  input  logic [7:0]    wdata_i,
  input  logic          acc_i,
  input  logic [AW-1:0] addr_nxt_i,
  input  logic [AW-1:0] cnt_nxt_i,
  input  logic          done_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] cnt_o,
  output logic          wide_o,
  output logic [AW-1:0] ring_first_o,
  output logic [AW-1:0] ring_stop_o,
  output logic [7:0]    status_o,
  output logic          irq_o
);
  localparam int PW = AW - 8;

  logic [AW-1:0] addr_q, cnt_q;
  logic [PW-1:0] first_q, stop_q;
  logic [6:0]    mask_q;
  logic [7:0]    status_q, st_set, st_clr;
  logic          wide_q, cmd_go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (acc_i) begin
      addr_q <= addr_nxt_i;
      cnt_q  <= cnt_nxt_i;
    end else if (we_i) begin
      case (sel_i)
        RG_ADR_LO: addr_q[7:0]    <= wdata_i;
        RG_ADR_HI: addr_q[AW-1:8] <= wdata_i[PW-1:0];
        RG_CNT_LO: cnt_q[7:0]     <= wdata_i;
        RG_CNT_HI: cnt_q[AW-1:8]  <= wdata_i[PW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= '0;
      stop_q  <= '0;
      mask_q  <= '0;
      wide_q  <= 1'b0;
    end else if (we_i) begin
      case (sel_i)
        RG_RING_F: first_q <= wdata_i[PW-1:0];
        RG_RING_S: stop_q  <= wdata_i[PW-1:0];
        RG_MASK:   mask_q  <= wdata_i[6:0];
        RG_CFG:    wide_q  <= wdata_i[0];
        default: ;
      endcase
    end
  end

  // command write with halt clear releases reset flag; zero-count transfer completes at once
  assign cmd_go = we_i && (sel_i == RG_CMD) && !wdata_i[CMD_HALT];

  always_comb begin
    st_set          = '0;
    st_set[ST_DONE] = done_i || (cmd_go && (wdata_i[CMD_RRD] || wdata_i[CMD_RWR]) && (cnt_q == '0));
    st_clr          = '0;
    if (we_i && (sel_i == RG_CLR)) st_clr[6:0] = wdata_i[6:0];
    st_clr[ST_RST]  = cmd_go;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= 8'h80;
    else         status_q <= (status_q & ~st_clr) | st_set;
  end

  assign addr_o       = addr_q;
  assign cnt_o        = cnt_q;
  assign wide_o       = wide_q;
  assign ring_first_o = {first_q, 8'h00};
  assign ring_stop_o  = {stop_q, 8'h00};
  assign status_o     = status_q;
  assign irq_o        = |(status_q[6:0] & mask_q);

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == RG_CLR && wdata_i[ST_DONE] && !done_i) |=> !status_q[ST_DONE]);

  p_cmd_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == RG_CMD && !wdata_i[CMD_HALT] && wdata_i[CMD_RRD] && cnt_q == '0)
      |=> (status_q[ST_DONE] && !status_q[ST_RST]));
endmodule

// File: rtl/rdma_step.sv
module rdma_step #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] cnt_i,
  input  logic [2:0]    nbytes_i,
  input  logic [AW-1:0] ring_first_i,
  input  logic [AW-1:0] ring_stop_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] cnt_o,
  output logic          done_o
);
  logic [AW-1:0] step, sum;

  assign step   = AW'(nbytes_i);
  assign sum    = addr_i + step;
  assign addr_o = (sum == ring_stop_i) ? ring_first_i : sum;
  assign done_o = (cnt_i <= step);
  assign cnt_o  = done_o ? '0 : cnt_i - step;
endmodule

// File: rtl/rdma_store.sv
module rdma_store #(
  parameter int AW        = 16,
  parameter int LOW_BYTES = 32,
  parameter int WIN_BASE  = 16'h0400,
  parameter int WIN_BYTES = 1024
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    nbytes_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o
);
  localparam int DEPTH = LOW_BYTES + WIN_BYTES;
  localparam int IW    = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW:0]   end_a;
  logic          in_low, in_win, hit;
  logic [IW-1:0] idx;

  assign end_a  = {1'b0, addr_i} + (AW+1)'(nbytes_i);
  assign in_low = end_a <= (AW+1)'(LOW_BYTES);
  assign in_win = (addr_i >= AW'(WIN_BASE)) && (end_a <= (AW+1)'(WIN_BASE + WIN_BYTES));
  assign hit    = in_low || in_win;
  assign idx    = in_low ? IW'(addr_i) : IW'(addr_i - AW'(WIN_BASE)) + IW'(LOW_BYTES);

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < 4; i++) begin
      if (wr_i && hit && (3'(i) < nbytes_i)) mem[idx + IW'(i)] <= wdata_i[8*i +: 8];
    end
  end

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           q <= '0;
      else if (rd_i && (3'(l) >= nbytes_i))  q <= '0;
      else if (rd_i)                         q <= hit ? mem[idx + IW'(l)] : 8'hff;
    end
    assign rdata_o[8*l +: 8] = q;
  end

  p_oob_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !hit && nbytes_i == 3'd4) |=> (rdata_o == 32'hffff_ffff));

  p_lane_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && nbytes_i == 3'd1) |=> (rdata_o[31:8] == 24'h0));
endmodule

// File: rtl/rdma_port.sv
module rdma_port
  import rdma_pkg::*;
#(
  parameter int AW        = 16,
  parameter int LOW_BYTES = 32,
  parameter int WIN_BASE  = 16'h0400,
  parameter int WIN_BYTES = 1024
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [3:0]  reg_sel_i,
  input  logic [7:0]  reg_wdata_i,
  input  logic        dp_rd_i,
  input  logic        dp_wr_i,
  input  logic [1:0]  dp_size_i,
  input  logic [31:0] dp_wdata_i,
  output logic [31:0] dp_rdata_o,
  output logic [7:0]  status_o,
  output logic        irq_o
);
  logic [AW-1:0] addr, cnt, addr_nxt, cnt_nxt, first_a, stop_a, acc_addr;
  logic [2:0]    nbytes;
  logic          wide, done, acc_rd, acc_wr, acc;

  assign nbytes   = (dp_size_i >= 2'd2) ? 3'd4 : (wide ? 3'd2 : 3'd1);
  assign acc_rd   = dp_rd_i;
  assign acc_wr   = dp_wr_i && !dp_rd_i && (cnt != '0);
  assign acc      = acc_rd || acc_wr;
  assign acc_addr = (nbytes == 3'd1) ? addr : {addr[AW-1:1], 1'b0};

  rdma_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .acc_i(acc), .addr_nxt_i(addr_nxt), .cnt_nxt_i(cnt_nxt), .done_i(acc && done),
    .addr_o(addr), .cnt_o(cnt), .wide_o(wide),
    .ring_first_o(first_a), .ring_stop_o(stop_a),
    .status_o, .irq_o
  );

  rdma_step #(.AW(AW)) u_step (
    .addr_i(addr), .cnt_i(cnt), .nbytes_i(nbytes),
    .ring_first_i(first_a), .ring_stop_i(stop_a),
    .addr_o(addr_nxt), .cnt_o(cnt_nxt), .done_o(done)
  );

  rdma_store #(.AW(AW), .LOW_BYTES(LOW_BYTES), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)) u_store (
    .clk_i, .rst_ni,
    .rd_i(acc_rd), .wr_i(acc_wr), .addr_i(acc_addr), .nbytes_i(nbytes),
    .wdata_i(dp_wdata_i), .rdata_o(dp_rdata_o)
  );

  p_wr_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_wr_i && !dp_rd_i && cnt == '0 && !reg_we_i) |=> ($stable(addr) && $stable(cnt)));

  p_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cnt > AW'(nbytes)) |=> (cnt == $past(cnt) - AW'($past(nbytes))));

  p_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cnt <= AW'(nbytes)) |=> (cnt == '0 && status_o[ST_DONE]));

  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (addr + AW'(nbytes)) == stop_a) |=> (addr == $past(first_a)));
endmodule

// File: tb/sim_rdma_port.sv
module sim_rdma_port;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_sel_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic        dp_rd_i = 1'b0;
  logic        dp_wr_i = 1'b0;
  logic [1:0]  dp_size_i = '0;
  logic [31:0] dp_wdata_i = '0;
  logic [31:0] dp_rdata_o;
  logic [7:0]  status_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0]  bm [2048];
  logic [15:0] m_addr = '0;
  logic [15:0] m_cnt = '0;
  logic [7:0]  m_isr = 8'h80;
  logic        m_wide = 1'b0;
  logic [7:0]  m_first = '0;
  logic [7:0]  m_stop = '0;

  always #10 clk_i = ~clk_i;

  rdma_port u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  function automatic bit in_map(input logic [15:0] a, input int n);
    int e;
    e = int'(a) + n;
    return (e <= 32) || (int'(a) >= 'h400 && e <= 'h800);
  endfunction

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  task automatic wreg(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = s; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    case (s)
      4'd0: if (!d[0]) begin
              m_isr[7] = 1'b0;
              if ((d[3] || d[4]) && m_cnt == 16'h0) m_isr[6] = 1'b1;
            end
      4'd1: m_addr[7:0]  = d;
      4'd2: m_addr[15:8] = d;
      4'd3: m_cnt[7:0]   = d;
      4'd4: m_cnt[15:8]  = d;
      4'd5: m_first      = d;
      4'd6: m_stop       = d;
      4'd7: m_wide       = d[0];
      4'd9: m_isr        = m_isr & ~{1'b0, d[6:0]};
      default: ;
    endcase
  endtask

  task automatic seta(input logic [15:0] a, input logic [15:0] c);
    wreg(4'd1, a[7:0]); wreg(4'd2, a[15:8]);
    wreg(4'd3, c[7:0]); wreg(4'd4, c[15:8]);
  endtask

  task automatic dacc(input bit wr, input logic [1:0] sz, input logic [31:0] wd, input string tag);
    int n;
    logic [15:0] a;
    bit ok;
    logic [31:0] exp;
    n   = (sz >= 2'd2) ? 4 : (m_wide ? 2 : 1);
    a   = (n == 1) ? m_addr : {m_addr[15:1], 1'b0};
    ok  = in_map(a, n);
    exp = '0;
    for (int i = 0; i < n; i++) exp[8*i +: 8] = ok ? bm[(int'(a) + i) & 2047] : 8'hff;
    @(negedge clk_i);
    dp_rd_i = !wr; dp_wr_i = wr; dp_size_i = sz; dp_wdata_i = wd;
    @(negedge clk_i);
    dp_rd_i = 1'b0; dp_wr_i = 1'b0;
    if (!(wr && m_cnt == 16'h0)) begin
      if (wr && ok) for (int i = 0; i < n; i++) bm[(int'(a) + i) & 2047] = wd[8*i +: 8];
      m_addr = m_addr + 16'(n);
      if (m_addr == {m_stop, 8'h00}) m_addr = {m_first, 8'h00};
      if (m_cnt <= 16'(n)) begin
        m_cnt = '0; m_isr[6] = 1'b1;
      end else m_cnt = m_cnt - 16'(n);
    end
    if (!wr) chk(tag, dp_rdata_o, exp);
    chk({tag, " status"}, {24'h0, status_o}, {24'h0, m_isr});
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog act timeout exp done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 reset status", {24'h0, status_o}, 32'h80);
    chk("R10 reset irq", {31'h0, irq_o}, 32'h0);
    chk("R10 reset rdata", dp_rdata_o, 32'h0);

    wreg(4'd8, 8'h80);
    chk("R10 bit7 never drives irq", {31'h0, irq_o}, 32'h0);
    wreg(4'd0, 8'h08);
    chk("R7 zero-count command", {24'h0, status_o}, 32'h40);
    chk("R10 unmasked done", {31'h0, irq_o}, 32'h0);
    wreg(4'd8, 8'hC0);
    chk("R10 masked done", {31'h0, irq_o}, 32'h1);
    wreg(4'd9, 8'h40);
    chk("R9 clear done", {24'h0, status_o}, 32'h00);
    chk("R9 irq low", {31'h0, irq_o}, 32'h0);
    wreg(4'd0, 8'h11);
    chk("R7 halted command", {24'h0, status_o}, 32'h00);

    wreg(4'd5, 8'h04); wreg(4'd6, 8'h08);
    seta(16'h0400, 16'd300);
    for (int k = 0; k < 300; k++) dacc(1'b1, 2'd0, {24'h0, pat(k)}, "R5 byte write");
    chk("R10 irq after done", {31'h0, irq_o}, 32'h1);
    wreg(4'd9, 8'h40);

    wreg(4'd1, 8'h00); wreg(4'd3, 8'h2C);
    for (int k = 0; k < 44; k++) dacc(1'b0, 2'd0, '0, "R1 half load");
    seta(16'h0400, 16'd300);
    for (int k = 0; k < 300; k++) dacc(1'b0, 2'd0, '0, "R2 byte readback");

    wreg(4'd7, 8'h01);
    seta(16'h0601, 16'd9);
    for (int k = 0; k < 5; k++) dacc(1'b1, 2'd1, {16'h0, pat(k), pat(k + 50)}, "R3 word write");
    wreg(4'd7, 8'h00);
    seta(16'h0600, 16'd10);
    for (int k = 0; k < 10; k++) dacc(1'b0, 2'd0, '0, "R2 little-endian bytes");

    seta(16'h0700, 16'd12);
    for (int k = 0; k < 3; k++)
      dacc(1'b1, 2'd2, {pat(k), pat(k + 1), pat(k + 2), pat(k + 3)}, "R2 long write");
    wreg(4'd7, 8'h01);
    seta(16'h0700, 16'd12);
    for (int k = 0; k < 6; k++) dacc(1'b0, 2'd0, '0, "R2 word readback");
    seta(16'h0703, 16'd8);
    for (int k = 0; k < 2; k++) dacc(1'b0, 2'd3, '0, "R3 long odd address");

    wreg(4'd5, 8'h06); wreg(4'd6, 8'h07);
    wreg(4'd7, 8'h00);
    seta(16'h06FC, 16'd8);
    for (int k = 0; k < 8; k++) dacc(1'b1, 2'd0, {24'h0, pat(k + 90)}, "R4 byte wrap");
    seta(16'h0600, 16'd4);
    for (int k = 0; k < 4; k++) dacc(1'b0, 2'd0, '0, "R4 wrap readback");
    wreg(4'd7, 8'h01);
    seta(16'h06FE, 16'd2);
    dacc(1'b1, 2'd0, 32'h0000_C3D4, "R4 word wrap");
    dacc(1'b0, 2'd0, '0, "R4 after word wrap");
    seta(16'h06FD, 16'd4);
    dacc(1'b0, 2'd2, '0, "R4 long no wrap");
    wreg(4'd7, 8'h00);
    dacc(1'b0, 2'd0, '0, "R4 past stop");

    wreg(4'd5, 8'h04); wreg(4'd6, 8'h08);
    wreg(4'd9, 8'h40);
    wreg(4'd7, 8'h01);
    seta(16'h0400, 16'd5);
    for (int k = 0; k < 3; k++) dacc(1'b0, 2'd0, '0, "R5 odd count");
    wreg(4'd9, 8'h40);

    wreg(4'd7, 8'h00);
    seta(16'h0410, 16'd0);
    dacc(1'b1, 2'd0, 32'h0000_00EE, "R6 write at zero count");
    wreg(4'd3, 8'h01);
    dacc(1'b0, 2'd0, '0, "R6 old byte kept");
    wreg(4'd9, 8'h40);

    seta(16'h0005, 16'd4);
    for (int k = 0; k < 4; k++) dacc(1'b1, 2'd0, {24'h0, pat(k + 200)}, "R8 low write");
    seta(16'h0005, 16'd4);
    for (int k = 0; k < 4; k++) dacc(1'b0, 2'd0, '0, "R8 low read");
    seta(16'h001C, 16'd4);
    dacc(1'b1, 2'd2, 32'hA5B6_C7D8, "R8 low long write");
    seta(16'h001C, 16'd4);
    dacc(1'b0, 2'd2, '0, "R8 low long read");
    seta(16'h001E, 16'd4);
    dacc(1'b0, 2'd2, '0, "R8 straddle low edge");
    seta(16'h0100, 16'd4);
    dacc(1'b1, 2'd0, 32'h0000_0012, "R8 gap write");
    seta(16'h0100, 16'd4);
    dacc(1'b0, 2'd0, '0, "R8 gap byte");
    wreg(4'd7, 8'h01);
    dacc(1'b0, 2'd0, '0, "R8 gap word");
    seta(16'h03FE, 16'd4);
    dacc(1'b0, 2'd0, '0, "R8 below window");
    seta(16'h07FC, 16'd4);
    dacc(1'b1, 2'd2, 32'h1357_9BDF, "R8 window top write");
    seta(16'h07FC, 16'd4);
    dacc(1'b0, 2'd2, '0, "R8 window top read");
    seta(16'h07FE, 16'd4);
    dacc(1'b0, 2'd2, '0, "R8 straddle window end");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule